// File: doc/BRIEF.md
# Serial infrared 3/16 pulse codec

This block sits between a standard UART and an infrared transceiver. On the transmit side it takes the NRZ bit that the UART presents and sends it as infrared pulses. A 0 bit becomes a short pulse that covers three of the sixteen oversampling ticks in its bit period. A 1 bit leaves the line at its idle level. On the receive side it takes the raw infrared input, qualifies pulses, and rebuilds an NRZ stream that an ordinary UART receiver can sample.

Transmit and receive polarity are chosen independently, so the block can drive and listen to transceivers of either sense. Receive qualification has two modes. The default mode takes a majority vote over consecutive samples taken on the 16x tick. The other mode suits pulses too short for that vote: a pulse is accepted once it has stayed active for a fixed number of reference-clock ticks. Each accepted pulse holds the recovered line low for one bit period. Each accepted pulse can also raise a one-cycle activity interrupt. Baud generation and character framing belong to the surrounding UART.

Top module: `irPulseCodec`

## Requirements
- R1: While reset is held, irOut sits at its idle level, which equals txInvert; rxNrz is 1 and irIntPulse is 0.
- R2: The 16x ticks after reset are numbered from 0 to 15 in a repeating count. The tick numbered 0 captures txNrz as the current bit. For a captured 0, irOut is active while the count is 7, 8 or 9 and idle for the rest of the bit. For a captured 1, irOut stays idle for all sixteen ticks. irOut changes only in the cycle after a tick.
- R3: With txInvert = 0 the active level of irOut is 1 and the idle level is 0. With txInvert = 1 the active level is 0 and the idle level is 1.
- R4: With rxInvert = 0 a low level on irIn counts as pulse-active. With rxInvert = 1 a high level on irIn counts as pulse-active.
- R5: With useRefClk = 0, the block synchronises irIn and samples it on each 16x tick. A pulse is accepted on the tick where at least 2 of the last 3 samples are active, having been fewer before. A pulse seen on only one sample is rejected.
- R6: With useRefClk = 0, an accepted pulse drives rxNrz to 0 from the accepting tick for 16 ticks. A new acceptance reloads this window, so consecutive 0 bits give a continuous low. rxNrz returns to 1 only on a tick.
- R7: With ticks at least 3 clocks apart and irIn looped back from irOut under matching polarities, rxNrz after tick n (counted from 1 after reset) equals the bit captured at tick n−9. For n < 10 it is 1.
- R8: With useRefClk = 1, the 16x samples are ignored. A pulse is accepted on the 4th refTick (REF_QUAL_COUNT) seen while the synchronised input stays active. A pulse covering fewer refTicks is rejected, even when it would have passed the 16x vote. An accepted pulse holds rxNrz low for 17 ticks.
- R9: If irIntEn = 1, each accepted pulse gives exactly one irIntPulse cycle, in the clock after acceptance. If irIntEn = 0, irIntPulse stays 0, but rxNrz still goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| txNrz | input | 1 | NRZ transmit bit from the UART |
| sampleTick | input | 1 | One-cycle 16x oversampling enable |
| refTick | input | 1 | One-cycle reference clock enable |
| irIn | input | 1 | Raw infrared receive input |
| txInvert | input | 1 | Transmit polarity select (1 = active-low pulses) |
| rxInvert | input | 1 | Receive polarity select (1 = active-high pulses) |
| useRefClk | input | 1 | Receive qualification mode (1 = reference-clock count) |
| irIntEn | input | 1 | Enable for the activity interrupt |
| irOut | output | 1 | Infrared output pin |
| rxNrz | output | 1 | Recovered NRZ receive bit |
| irIntPulse | output | 1 | One-cycle pulse per accepted infrared pulse |

## Verification
The properties assume the following about the inputs:
- sampleTick never fires in two consecutive cycles.
- txInvert, rxInvert, useRefClk and irIntEn change only while reset is held.
- The transmitter's bit timing follows the tick count from reset.

The stimulus keeps to all of these:
- A divider produces ticks every four clocks and reference ticks on a fixed schedule.
- Every control change is applied inside a reset phase.
- txNrz is updated only between the tick numbered 15 and the tick numbered 0 that captures it.

The loopback runs feed the receiver only with pulses of the matching polarity.

// File: rtl/irCodecPkg.sv
package irCodecPkg;

  // Strobes and levels issued by the control unit to the datapath
  typedef struct packed {
    logic txLatch;      // capture txNrz as the new bit
    logic txPulseSlot;  // tick phase lies inside the pulse slot
    logic sampleEn;     // take a vote sample this cycle
    logic rxLow;        // recovered line held low
    logic qualify;      // a pulse was accepted this cycle
  } irStrobesT;

  // Conditions reported by the datapath back to the control unit
  typedef struct packed {
    logic rxActive;     // synchronised input is at its active level
    logic voteRise;     // vote becomes true on this sample
  } irStatusT;

endpackage

// File: rtl/irControl.sv
module irControl
  import irCodecPkg::*;
#(
  parameter int SAMPLES_PER_BIT = 16,
  parameter int PULSE_START     = 7,
  parameter int PULSE_LEN       = 3,
  parameter int REF_QUAL_COUNT  = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sampleTick,
  input  logic      refTick,
  input  logic      useRefClk,
  input  irStatusT  status,
  output irStrobesT strobes
);

  localparam int PHASE_W = $clog2(SAMPLES_PER_BIT);
  localparam int WIN_W   = $clog2(SAMPLES_PER_BIT + 2);
  localparam int REF_W   = $clog2(REF_QUAL_COUNT + 1);
  localparam logic [PHASE_W-1:0] PHASE_LAST = PHASE_W'(SAMPLES_PER_BIT - 1);
  localparam logic [PHASE_W-1:0] SLOT_FIRST = PHASE_W'(PULSE_START);
  localparam logic [PHASE_W-1:0] SLOT_LAST  = PHASE_W'(PULSE_START + PULSE_LEN - 1);
  localparam logic [WIN_W-1:0]   WIN_TICK   = WIN_W'(SAMPLES_PER_BIT);
  // one extra tick in reference mode because acceptance falls between ticks
  localparam logic [WIN_W-1:0]   WIN_REF    = WIN_W'(SAMPLES_PER_BIT + 1);
  localparam logic [REF_W-1:0]   REF_FULL   = REF_W'(REF_QUAL_COUNT);
  localparam logic [REF_W-1:0]   REF_HIT    = REF_W'(REF_QUAL_COUNT - 1);

  logic [PHASE_W-1:0] txPhase;
  logic [WIN_W-1:0]   winCnt;
  logic [REF_W-1:0]   refCnt;
  logic               refHit;
  logic               qualifyNow;

  // transmit phase: reset to the last phase so the first tick opens bit 0
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txPhase <= PHASE_LAST;
    end else if (sampleTick) begin
      txPhase <= (txPhase == PHASE_LAST) ? '0 : txPhase + 1'b1;
    end
  end

  // reference-clock qualifier: counts refTicks during one active stretch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refCnt <= '0;
    end else if (!useRefClk || !status.rxActive) begin
      refCnt <= '0;
    end else if (refTick && (refCnt != REF_FULL)) begin
      refCnt <= refCnt + 1'b1;
    end
  end

  assign refHit     = useRefClk && refTick && status.rxActive && (refCnt == REF_HIT);
  assign qualifyNow = useRefClk ? refHit : status.voteRise;

  // low window of the recovered line, reloaded by every accepted pulse
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winCnt <= '0;
    end else if (qualifyNow) begin
      winCnt <= useRefClk ? WIN_REF : WIN_TICK;
    end else if (sampleTick && (winCnt != '0)) begin
      winCnt <= winCnt - 1'b1;
    end
  end

  always_comb begin
    strobes.txLatch     = sampleTick && (txPhase == PHASE_LAST);
    strobes.txPulseSlot = (txPhase >= SLOT_FIRST) && (txPhase <= SLOT_LAST);
    strobes.sampleEn    = sampleTick && !useRefClk;
    strobes.rxLow       = (winCnt != '0);
    strobes.qualify     = qualifyNow;
  end

endmodule

// File: rtl/irDatapath.sv
module irDatapath
  import irCodecPkg::*;
#(
  parameter int VOTE_TAPS   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      txNrz,
  input  logic      irIn,
  input  logic      txInvert,
  input  logic      rxInvert,
  input  logic      irIntEn,
  input  irStrobesT strobes,
  output irStatusT  status,
  output logic      irOut,
  output logic      rxNrz,
  output logic      irIntPulse
);

  localparam int VOTE_NEED = VOTE_TAPS / 2 + 1;

  logic                   txBit;
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   rxActive;
  logic                   voteRise;

  // transmit bit register and pulse shaping
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBit <= 1'b1;
    end else if (strobes.txLatch) begin
      txBit <= txNrz;
    end
  end

  assign irOut = txInvert ^ (strobes.txPulseSlot & ~txBit);

  // input synchroniser, preset to the idle level of the chosen polarity
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= {SYNC_STAGES{~rxInvert}};
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], irIn};
    end
  end

  assign rxActive = ~(syncQ[SYNC_STAGES-1] ^ rxInvert);

  generate
    if (VOTE_TAPS > 1) begin : gVote
      logic [VOTE_TAPS-1:0] voteSh;
      logic [VOTE_TAPS-1:0] voteNext;

      assign voteNext = {voteSh[VOTE_TAPS-2:0], rxActive};

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          voteSh <= '0;
        end else if (strobes.sampleEn) begin
          voteSh <= voteNext;
        end
      end

      assign voteRise = strobes.sampleEn &&
                        ($countones(voteNext) >= VOTE_NEED) &&
                        ($countones(voteSh) < VOTE_NEED);
    end else begin : gSingle
      logic lastSample;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          lastSample <= 1'b0;
        end else if (strobes.sampleEn) begin
          lastSample <= rxActive;
        end
      end

      assign voteRise = strobes.sampleEn && rxActive && !lastSample;
    end
  endgenerate

  always_comb begin
    status.rxActive = rxActive;
    status.voteRise = voteRise;
  end

  assign rxNrz = ~strobes.rxLow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irIntPulse <= 1'b0;
    end else begin
      irIntPulse <= strobes.qualify && irIntEn;
    end
  end

endmodule

// File: rtl/irPulseCodec.sv
module irPulseCodec
  import irCodecPkg::*;
#(
  parameter int SAMPLES_PER_BIT = 16,
  parameter int PULSE_START     = 7,
  parameter int PULSE_LEN       = 3,
  parameter int VOTE_TAPS       = 3,
  parameter int SYNC_STAGES     = 2,
  parameter int REF_QUAL_COUNT  = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic txNrz,
  input  logic sampleTick,
  input  logic refTick,
  input  logic irIn,
  input  logic txInvert,
  input  logic rxInvert,
  input  logic useRefClk,
  input  logic irIntEn,
  output logic irOut,
  output logic rxNrz,
  output logic irIntPulse
);

  irStrobesT strobes;
  irStatusT  status;

  irControl #(
    .SAMPLES_PER_BIT(SAMPLES_PER_BIT),
    .PULSE_START    (PULSE_START),
    .PULSE_LEN      (PULSE_LEN),
    .REF_QUAL_COUNT (REF_QUAL_COUNT)
  ) i_control (
    .clk       (clk),
    .rstN      (rstN),
    .sampleTick(sampleTick),
    .refTick   (refTick),
    .useRefClk (useRefClk),
    .status    (status),
    .strobes   (strobes)
  );

  irDatapath #(
    .VOTE_TAPS  (VOTE_TAPS),
    .SYNC_STAGES(SYNC_STAGES)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .txNrz     (txNrz),
    .irIn      (irIn),
    .txInvert  (txInvert),
    .rxInvert  (rxInvert),
    .irIntEn   (irIntEn),
    .strobes   (strobes),
    .status    (status),
    .irOut     (irOut),
    .rxNrz     (rxNrz),
    .irIntPulse(irIntPulse)
  );

endmodule

// File: rtl/irPulseCodecChecker.sv
module irPulseCodecChecker (
  input logic clk,
  input logic rstN,
  input logic sampleTick,
  input logic refTick,
  input logic txInvert,
  input logic useRefClk,
  input logic irIntEn,
  input logic irOut,
  input logic rxNrz,
  input logic irIntPulse
);

  // R1: idle outputs while reset is held
  always @(posedge clk) begin
    if (!rstN) begin
      assert_reset_idle_R1: assert ((irOut == txInvert) && rxNrz && !irIntPulse)
        else $error("reset state wrong");
    end
  end

  // R2: a transmit pulse only begins right after a tick
  assert_tx_start_on_tick_R2: assert property (@(posedge clk) disable iff (!rstN)
    ((irOut != txInvert) && !$past(irOut != txInvert)) |-> $past(sampleTick));

  // R5: in vote mode the recovered line falls only on a tick
  assert_rx_fall_on_tick_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(rxNrz) && !useRefClk) |-> $past(sampleTick));

  // R6: the low window ends only on a tick
  assert_rx_rise_on_tick_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxNrz) |-> $past(sampleTick));

  // R6: an interrupt is accompanied by a low recovered line
  assert_rx_low_with_int_R6: assert property (@(posedge clk) disable iff (!rstN)
    irIntPulse |-> !rxNrz);

  // R8: in reference mode the line falls only on a reference tick
  assert_rx_fall_on_ref_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(rxNrz) && useRefClk) |-> $past(refTick));

  // R9: interrupt lasts one cycle and needs the enable
  assert_int_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    irIntPulse |=> !irIntPulse);

  assert_int_needs_enable_R9: assert property (@(posedge clk) disable iff (!rstN)
    irIntPulse |-> $past(irIntEn));

endmodule

bind irPulseCodec irPulseCodecChecker i_checker (
  .clk       (clk),
  .rstN      (rstN),
  .sampleTick(sampleTick),
  .refTick   (refTick),
  .txInvert  (txInvert),
  .useRefClk (useRefClk),
  .irIntEn   (irIntEn),
  .irOut     (irOut),
  .rxNrz     (rxNrz),
  .irIntPulse(irIntPulse)
);

// File: tb/test_irPulseCodec.sv
module test_irPulseCodec;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int BIT_TICKS  = 16;
  localparam int RX_LAG     = 10;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txNrz = 1'b1;
  logic sampleTick = 1'b0;
  logic refTick = 1'b0;
  logic manualIr = 1'b0;
  logic loopback = 1'b1;
  logic txInvert = 1'b0;
  logic rxInvert = 1'b1;
  logic useRefClk = 1'b0;
  logic irIntEn = 1'b1;
  logic irInW;
  logic irOut;
  logic rxNrz;
  logic irIntPulse;

  int checks = 0;
  int fails = 0;
  int tkCount = 0;
  int lastTk = 0;
  int intCount = 0;
  int divCnt = 0;
  bit monitorOn = 1'b0;
  bit txQ[$];
  bit rxQ[$];

  assign irInW = loopback ? irOut : manualIr;

  irPulseCodec i_irPulseCodec (
    .clk       (clk),
    .rstN      (rstN),
    .txNrz     (txNrz),
    .sampleTick(sampleTick),
    .refTick   (refTick),
    .irIn      (irInW),
    .txInvert  (txInvert),
    .rxInvert  (rxInvert),
    .useRefClk (useRefClk),
    .irIntEn   (irIntEn),
    .irOut     (irOut),
    .rxNrz     (rxNrz),
    .irIntPulse(irIntPulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic void check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endfunction

  // tick generators, driven away from the active edge
  always @(negedge clk) begin
    if (!rstN) begin
      divCnt = 0;
      sampleTick = 1'b0;
      refTick = 1'b0;
    end else begin
      sampleTick = (divCnt == TICK_DIV - 1);
      refTick = (divCnt == 1);
      divCnt = (divCnt + 1) % TICK_DIV;
    end
  end

  always @(posedge clk or negedge rstN) begin
    if (!rstN) tkCount <= 0;
    else if (sampleTick) tkCount <= tkCount + 1;
  end

  // monitor: one comparison per tick for each scoreboard queue
  always @(negedge clk) begin
    if (!rstN) begin
      lastTk = 0;
    end else begin
      if (irIntPulse) intCount++;
      if (monitorOn && (tkCount != lastTk)) begin
        lastTk = tkCount;
        if (txQ.size() > 0) begin
          bit e;
          e = txQ.pop_front();
          check(irOut == e, "R2 R3 irOut", int'(irOut), int'(e));
        end
        if (lastTk < RX_LAG) begin
          check(rxNrz == 1'b1, "R7 rxNrz before lag", int'(rxNrz), 1);
        end else if (rxQ.size() > 0) begin
          bit r;
          r = rxQ.pop_front();
          check(rxNrz == r, "R7 R6 R4 rxNrz", int'(rxNrz), int'(r));
        end
      end
    end
  end

  task automatic doReset(bit tInv, bit rInv, bit useRef, bit intEn, bit loop);
    rstN = 1'b0;
    monitorOn = 1'b0;
    txQ.delete();
    rxQ.delete();
    txInvert = tInv;
    rxInvert = rInv;
    useRefClk = useRef;
    irIntEn = intEn;
    loopback = loop;
    manualIr = ~rInv;
    txNrz = 1'b1;
    repeat (3) @(negedge clk);
    check(irOut == tInv, "R1 irOut idle", int'(irOut), int'(tInv));
    check(rxNrz == 1'b1, "R1 rxNrz", int'(rxNrz), 1);
    check(irIntPulse == 1'b0, "R1 irIntPulse", int'(irIntPulse), 0);
    intCount = 0;
    rstN = 1'b1;
  endtask

  // driver: sends bits and pushes the expected per-tick values
  task automatic sendBits(bit tInv, bit rInv, bit intEn, logic [15:0] pat, int n);
    int zeros = 0;
    doReset(tInv, rInv, 1'b0, intEn, 1'b1);
    monitorOn = 1'b1;
    for (int b = 0; b < n + 2; b++) begin
      bit v;
      v = (b < n) ? pat[b] : 1'b1;
      if (!v) zeros++;
      wait (tkCount == BIT_TICKS * b);
      @(negedge clk);
      txNrz = v;
      for (int p = 0; p < BIT_TICKS; p++) begin
        bit act;
        act = (p >= 7) && (p <= 9) && !v;
        txQ.push_back(tInv ^ act);
        rxQ.push_back(v);
      end
    end
    wait (tkCount == BIT_TICKS * (n + 2) + RX_LAG);
    @(negedge clk);
    check(intCount == (intEn ? zeros : 0), "R9 interrupt count", intCount, intEn ? zeros : 0);
    monitorOn = 1'b0;
  endtask

  task automatic waitTickEdge();
    int t0;
    t0 = tkCount;
    wait (tkCount != t0);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : mainSeq
    int minRx;
    // loopback runs in both polarity pairs, with and without interrupt
    sendBits(1'b0, 1'b1, 1'b1, 16'b0000_0000_1011_0010, 8);
    sendBits(1'b1, 1'b0, 1'b1, 16'b0000_0000_0010_0001, 6);
    sendBits(1'b0, 1'b1, 1'b0, 16'b0000_0000_0000_0010, 3);

    // R5: one-sample glitch is rejected (active-low input, R4)
    doReset(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    waitTickEdge();
    waitTickEdge();
    manualIr = 1'b0;
    repeat (TICK_DIV) @(negedge clk);
    manualIr = 1'b1;
    minRx = 1;
    for (int i = 0; i < 30 * TICK_DIV; i++) begin
      @(negedge clk);
      if (!rxNrz) minRx = 0;
    end
    check(minRx == 1, "R5 glitch rejected rxNrz", minRx, 1);
    check(intCount == 0, "R5 glitch no interrupt", intCount, 0);

    // R5: two-sample pulse is accepted on its second sample
    waitTickEdge();
    check(rxNrz == 1'b1, "R5 before pulse", int'(rxNrz), 1);
    manualIr = 1'b0;
    repeat (2 * TICK_DIV) @(negedge clk);
    manualIr = 1'b1;
    check(rxNrz == 1'b0, "R5 two samples accepted", int'(rxNrz), 0);
    check(irIntPulse == 1'b1, "R9 interrupt after accept", int'(irIntPulse), 1);
    @(negedge clk);
    check(irIntPulse == 1'b0, "R9 interrupt one cycle", int'(irIntPulse), 0);
    repeat (15 * TICK_DIV - 1) @(negedge clk);
    check(rxNrz == 1'b0, "R6 window last tick", int'(rxNrz), 0);
    repeat (TICK_DIV) @(negedge clk);
    check(rxNrz == 1'b1, "R6 window ended", int'(rxNrz), 1);
    check(intCount == 1, "R9 single interrupt", intCount, 1);

    // R8: reference mode, active-high input
    doReset(1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    repeat (20) @(negedge clk);
    manualIr = 1'b1;
    repeat (2 * TICK_DIV) @(negedge clk);
    manualIr = 1'b0;
    minRx = 1;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (!rxNrz) minRx = 0;
    end
    check(minRx == 1, "R8 short pulse rejected", minRx, 1);
    check(intCount == 0, "R8 short pulse no interrupt", intCount, 0);
    manualIr = 1'b1;
    repeat (6 * TICK_DIV) @(negedge clk);
    manualIr = 1'b0;
    check(rxNrz == 1'b0, "R8 long pulse accepted", int'(rxNrz), 0);
    check(intCount == 1, "R8 R9 long pulse interrupt", intCount, 1);
    repeat (30) @(negedge clk);
    check(rxNrz == 1'b0, "R8 window held", int'(rxNrz), 0);
    repeat (100) @(negedge clk);
    check(rxNrz == 1'b1, "R8 window ended", int'(rxNrz), 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule